// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Tracker

This block follows the progress of a single DMA channel and generates its interrupt. Software programs an element count per frame and a frame count per block, then enables the channel. Each pulse on the synchronization input raises a pending-service flag. An external element-done strobe stands in for the completed transfer and retires that request. The block counts serviced elements into frames and frames into blocks.

It records three progress events: a frame has completed, the final frame of the block has started, and the whole block has completed. Each event is recorded only when its own interrupt enable is set. A synchronization pulse that arrives while the previous request is still pending is a dropped sync. The block always records it and interrupts on it only when asked to.

Software reads a 16-bit status word through a one-strobe read port, and that read clears the sticky flags. The interrupt request leaves the block as a single-cycle pulse.

Top module: `dma_chan_status`

## Requirements
- R1: The status word is 16 bits: bit 6 is SYNC (pending), bit 5 BLOCK, bit 4 LAST, bit 3 FRAME and bit 1 DROP. Bits 15 to 7, bit 2 and bit 0 always read 0, and all bits are 0 after reset.
- R2: While the channel is enabled, a `sync_in` pulse sets SYNC one cycle later. An `elem_done` pulse while SYNC is 1 clears it one cycle later and counts one element. An `elem_done` while SYNC is 0 is ignored and counts nothing.
- R3: A `sync_in` while SYNC is 1 and no `elem_done` in the same cycle sets DROP one cycle later, whatever `ie_drop` is. It pulses `irq` only if `ie_drop` is 1. A `sync_in` together with `elem_done` is not a drop and leaves SYNC at 1.
- R4: FRAME is set one cycle after the element that completes a frame (the `cfg_elem`-th serviced element of it), only if `ie_frame` is 1 in that cycle.
- R5: LAST is set one cycle after the channel enters the final frame, only if `ie_last` is 1. This happens in the enabling cycle when `cfg_frame` is 1; otherwise it happens with the completion of frame `cfg_frame`-1. With one frame per block, LAST comes at enable, and FRAME and BLOCK come together on the last element.
- R6: BLOCK is set one cycle after the last element of the last frame, only if `ie_block` is 1. The channel then stops, and later `sync_in` pulses have no effect until it is enabled again.
- R7: `irq` is high for exactly the one cycle in which an enabled event's flag first appears. Several events in the same cycle give a single pulse. Events whose enable is 0 give no pulse.
- R8: `rd_data` shows the current status while `rd_en` is high. After that cycle, BLOCK, LAST, FRAME and DROP are 0 and SYNC is unchanged. An event in the same cycle as the read leaves its flag set.
- R9: A rising edge of `chan_en` loads both counts, which must be at least 1, and restarts counting. Dropping `chan_en` clears SYNC one cycle later and stops the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; rising edge loads counts |
| cfg_elem | input | EW | Elements per frame (>= 1) |
| cfg_frame | input | FW | Frames per block (>= 1) |
| ie_frame | input | 1 | Frame-complete enable |
| ie_last | input | 1 | Final-frame-start enable |
| ie_block | input | 1 | Block-complete enable |
| ie_drop | input | 1 | Dropped-sync interrupt enable |
| sync_in | input | 1 | Synchronization event pulse |
| elem_done | input | 1 | Element transfer completed |
| rd_en | input | 1 | Status read strobe (clears flags) |
| rd_data | output | 16 | Status word |
| irq | output | 1 | Channel interrupt pulse |

## Verification
A counter that slips shows at the ports as FRAME, LAST or BLOCK appearing on the wrong element, one cycle after the offending `elem_done`. The bench catches it because it sweeps every small element and frame count and predicts the event for each element. A SYNC flag stuck high or low shows up as a missing or spurious DROP on the very next `sync_in`, and it also shows as a mismatch on the next status read. A wrong enable gate or a wrong clear priority shows as a wrong status word or a wrong `irq` level in the cycle right after the event.

// File: rtl/dma_chs_pkg.sv
package dma_chs_pkg;
    localparam int STAT_W    = 16;
    localparam int BIT_SYNC  = 6;
    localparam int BIT_BLOCK = 5;
    localparam int BIT_LAST  = 4;
    localparam int BIT_FRAME = 3;
    localparam int BIT_DROP  = 1;

    typedef struct packed {
        logic block;
        logic last;
        logic frame;
        logic drop;
    } chs_flags_t;
endpackage

// File: rtl/dma_chs_counter.sv
module dma_chs_counter #(
    parameter int EW = 8,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          stop,
    input  logic          step,
    input  logic [EW-1:0] cfg_elem,
    input  logic [FW-1:0] cfg_frame,
    output logic          active_o,
    output logic          frame_done_o,
    output logic          last_start_o,
    output logic          block_done_o
);
    localparam logic [EW-1:0] E_ONE = EW'(1);
    localparam logic [FW-1:0] F_ONE = FW'(1);
    localparam logic [FW-1:0] F_TWO = FW'(2);

    typedef struct packed {
        logic          active;
        logic [EW-1:0] elem_len;
        logic [EW-1:0] elem_left;
        logic [FW-1:0] frame_left;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       frame_done_d, last_start_d, block_done_d;

    always_comb begin
        st_d         = st_q;
        frame_done_d = 1'b0;
        last_start_d = 1'b0;
        block_done_d = 1'b0;
        if (load) begin
            st_d.active     = 1'b1;
            st_d.elem_len   = cfg_elem;
            st_d.elem_left  = cfg_elem;
            st_d.frame_left = cfg_frame;
            last_start_d    = (cfg_frame == F_ONE);
        end else if (stop) begin
            st_d.active = 1'b0;
        end else if (st_q.active && step) begin
            if (st_q.elem_left == E_ONE) begin
                frame_done_d   = 1'b1;
                st_d.elem_left = st_q.elem_len;
                if (st_q.frame_left == F_ONE) begin
                    block_done_d = 1'b1;
                    st_d.active  = 1'b0;
                end else begin
                    st_d.frame_left = st_q.frame_left - F_ONE;
                    last_start_d    = (st_q.frame_left == F_TWO);
                end
            end else begin
                st_d.elem_left = st_q.elem_left - E_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o     = st_q.active;
    assign frame_done_o = frame_done_d;
    assign last_start_o = last_start_d;
    assign block_done_o = block_done_d;
endmodule

// File: rtl/dma_chs_sync.sv
module dma_chs_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic sync_in,
    input  logic elem_done,
    output logic sync_o,
    output logic step_o,
    output logic drop_o
);
    typedef struct packed {
        logic pend;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        step_o = enabled && elem_done && st_q.pend;
        drop_o = enabled && sync_in && st_q.pend && !elem_done;
        if (!enabled) begin
            st_d.pend = 1'b0;
        end else begin
            st_d.pend = sync_in || (st_q.pend && !elem_done);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.pend;
endmodule

// File: rtl/dma_chs_status.sv
module dma_chs_status
    import dma_chs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_frame,
    input  logic              ev_last,
    input  logic              ev_block,
    input  logic              ev_drop,
    input  logic              ie_frame,
    input  logic              ie_last,
    input  logic              ie_block,
    input  logic              ie_drop,
    input  logic              rd_en,
    input  logic              sync_pend,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq
);
    typedef struct packed {
        chs_flags_t flags;
        logic       irq;
    } stat_state_t;

    stat_state_t st_d, st_q;
    chs_flags_t  set_v;

    always_comb begin
        set_v.frame = ev_frame && ie_frame;
        set_v.last  = ev_last  && ie_last;
        set_v.block = ev_block && ie_block;
        set_v.drop  = ev_drop;
        st_d        = st_q;
        if (rd_en) begin
            st_d.flags = set_v;
        end else begin
            st_d.flags = st_q.flags | set_v;
        end
        st_d.irq = set_v.frame || set_v.last || set_v.block || (ev_drop && ie_drop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data            = '0;
        rd_data[BIT_SYNC]  = sync_pend;
        rd_data[BIT_BLOCK] = st_q.flags.block;
        rd_data[BIT_LAST]  = st_q.flags.last;
        rd_data[BIT_FRAME] = st_q.flags.frame;
        rd_data[BIT_DROP]  = st_q.flags.drop;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status #(
    parameter int EW = 8,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic [EW-1:0] cfg_elem,
    input  logic [FW-1:0] cfg_frame,
    input  logic          ie_frame,
    input  logic          ie_last,
    input  logic          ie_block,
    input  logic          ie_drop,
    input  logic          sync_in,
    input  logic          elem_done,
    input  logic          rd_en,
    output logic [15:0]   rd_data,
    output logic          irq
);
    typedef struct packed {
        logic en;
    } top_state_t;

    top_state_t st_d, st_q;
    logic load, stop, enabled, active;
    logic step, drop, sync_pend;
    logic frame_done, last_start, block_done;

    always_comb begin
        st_d    = st_q;
        st_d.en = chan_en;
        load    = chan_en && !st_q.en;
        stop    = !chan_en;
        enabled = active && chan_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dma_chs_sync i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .enabled   (enabled),
        .sync_in   (sync_in),
        .elem_done (elem_done),
        .sync_o    (sync_pend),
        .step_o    (step),
        .drop_o    (drop)
    );

    dma_chs_counter #(.EW(EW), .FW(FW)) i_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .stop         (stop),
        .step         (step),
        .cfg_elem     (cfg_elem),
        .cfg_frame    (cfg_frame),
        .active_o     (active),
        .frame_done_o (frame_done),
        .last_start_o (last_start),
        .block_done_o (block_done)
    );

    dma_chs_status i_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_frame  (frame_done),
        .ev_last   (last_start),
        .ev_block  (block_done),
        .ev_drop   (drop),
        .ie_frame  (ie_frame),
        .ie_last   (ie_last),
        .ie_block  (ie_block),
        .ie_drop   (ie_drop),
        .rd_en     (rd_en),
        .sync_pend (sync_pend),
        .rd_data   (rd_data),
        .irq       (irq)
    );
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enabled,
    input logic        sync_in,
    input logic        elem_done,
    input logic        ie_frame,
    input logic        ie_last,
    input logic        ie_block,
    input logic [15:0] rd_data,
    input logic        irq
);
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15:7] == 9'd0) && !rd_data[2] && !rd_data[0]);

    assert_sync_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && elem_done && rd_data[6] && !sync_in) |=> !rd_data[6]);

    assert_drop_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && sync_in && rd_data[6] && !elem_done) |=> rd_data[1]);

    assert_frame_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[3]) |-> $past(ie_frame));

    assert_last_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[4]) |-> $past(ie_last));

    assert_block_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[5]) |-> $past(ie_block));

    assert_irq_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((rd_data[5:3] != 3'd0) || rd_data[1]));
endmodule

bind dma_chan_status dma_chan_status_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enabled   (enabled),
    .sync_in   (sync_in),
    .elem_done (elem_done),
    .ie_frame  (ie_frame),
    .ie_last   (ie_last),
    .ie_block  (ie_block),
    .rd_data   (rd_data),
    .irq       (irq)
);

// File: tb/test_dma_chan_status.sv
module test_dma_chan_status;
    localparam int EW = 4;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chan_en = 1'b0;
    logic [EW-1:0] cfg_elem = '0;
    logic [FW-1:0] cfg_frame = '0;
    logic          ie_frame = 1'b0, ie_last = 1'b0, ie_block = 1'b0, ie_drop = 1'b0;
    logic          sync_in = 1'b0, elem_done = 1'b0, rd_en = 1'b0;
    logic [15:0]   rd_data;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dma_chan_status #(.EW(EW), .FW(FW)) i_dma_chan_status (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_elem(cfg_elem),
        .cfg_frame(cfg_frame), .ie_frame(ie_frame), .ie_last(ie_last),
        .ie_block(ie_block), .ie_drop(ie_drop), .sync_in(sync_in),
        .elem_done(elem_done), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    localparam logic [15:0] S_SYNC = 16'h0040, S_BLOCK = 16'h0020,
                            S_LAST = 16'h0010, S_FRAME = 16'h0008, S_DROP = 16'h0002;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        sync_in = 1'b0; elem_done = 1'b0; rd_en = 1'b0;
    endtask

    task automatic enable_ch(input int e, input int f);
        cfg_elem = EW'(e); cfg_frame = FW'(f);
        chan_en = 1'b0; tick();
        chan_en = 1'b1; tick();
    endtask

    task automatic clear_rd;
        rd_en = 1'b1; tick();
    endtask

    initial begin
        #2ms;
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", rd_data, 16'h0000);
        chk("R7 reset irq", {15'd0, irq}, 16'd0);

        // Sweep of counts and enable masks
        for (int m = 0; m < 4; m++) begin
            for (int e = 1; e <= 3; e++) begin
                for (int f = 1; f <= 3; f++) begin
                    logic ief, iel, ieb;
                    ief = (m == 0) || (m == 2);
                    iel = (m == 0) || (m == 3);
                    ieb = (m == 0) || (m == 2) || (m == 3) ? (m != 3) : 1'b0;
                    ie_frame = ief; ie_last = iel; ie_block = ieb; ie_drop = 1'b0;
                    enable_ch(e, f);
                    exp = (iel && f == 1) ? S_LAST : 16'h0;
                    chk("R5 last at enable", rd_data, exp);
                    chk("R7 irq at enable", {15'd0, irq}, {15'd0, exp != 0});
                    clear_rd();
                    chk("R8 cleared", rd_data, 16'h0);
                    for (int fi = 1; fi <= f; fi++) begin
                        for (int ei = 1; ei <= e; ei++) begin
                            logic fd, bd, ls;
                            sync_in = 1'b1; tick();
                            chk("R2 sync pending", rd_data, S_SYNC);
                            elem_done = 1'b1; tick();
                            fd = (ei == e);
                            bd = fd && (fi == f);
                            ls = fd && (f > 1) && (fi == f - 1);
                            exp = ((fd && ief) ? S_FRAME : 16'h0) |
                                  ((bd && ieb) ? S_BLOCK : 16'h0) |
                                  ((ls && iel) ? S_LAST : 16'h0);
                            chk("R4 R5 R6 flags", rd_data, exp);
                            chk("R7 irq", {15'd0, irq}, {15'd0, exp != 0});
                            clear_rd();
                            chk("R7 irq one cycle", {15'd0, irq}, 16'd0);
                        end
                    end
                    sync_in = 1'b1; tick();
                    chk("R6 stopped after block", rd_data, 16'h0);
                end
            end
        end

        // R2: elem_done without a pending request counts nothing
        ie_frame = 1; ie_last = 1; ie_block = 1; ie_drop = 1;
        enable_ch(2, 1);
        clear_rd();
        elem_done = 1'b1; tick();
        elem_done = 1'b1; tick();
        chk("R2 stray elem ignored", rd_data, 16'h0);
        sync_in = 1'b1; tick(); elem_done = 1'b1; tick();
        chk("R2 first counted elem", rd_data, 16'h0);
        sync_in = 1'b1; tick(); elem_done = 1'b1; tick();
        chk("R2 second counted elem", rd_data, S_FRAME | S_BLOCK);
        chk("R7 single pulse for two events", {15'd0, irq}, 16'd1);
        tick();
        chk("R7 pulse ends", {15'd0, irq}, 16'd0);

        // R3: dropped sync
        enable_ch(8, 1);
        clear_rd();
        sync_in = 1'b1; tick();
        sync_in = 1'b1; tick();
        chk("R3 drop flagged", rd_data, S_SYNC | S_DROP);
        chk("R3 drop irq enabled", {15'd0, irq}, 16'd1);
        clear_rd();
        chk("R8 sync kept, drop cleared", rd_data, S_SYNC);
        ie_drop = 1'b0;
        sync_in = 1'b1; tick();
        chk("R3 drop flag without enable", rd_data, S_SYNC | S_DROP);
        chk("R3 no irq without enable", {15'd0, irq}, 16'd0);
        clear_rd();
        sync_in = 1'b1; elem_done = 1'b1; tick();
        chk("R3 sync with service not a drop", rd_data, S_SYNC);

        // R8: event in same cycle as clearing read
        enable_ch(1, 2);
        clear_rd();
        sync_in = 1'b1; tick();
        elem_done = 1'b1; rd_en = 1'b1;
        #1 chk("R8 read value", rd_data, S_SYNC);
        tick();
        chk("R8 set wins over clear", rd_data, S_FRAME | S_LAST);

        // R9: disable clears SYNC, re-enable reloads the counts
        enable_ch(2, 1);
        clear_rd();
        sync_in = 1'b1; tick(); elem_done = 1'b1; tick();
        sync_in = 1'b1; tick();
        chan_en = 1'b0; tick();
        chk("R9 disable clears sync", rd_data, 16'h0);
        chan_en = 1'b1; tick();
        clear_rd();
        sync_in = 1'b1; tick(); elem_done = 1'b1; tick();
        chk("R9 counts reloaded", rd_data, 16'h0);
        sync_in = 1'b1; tick(); elem_done = 1'b1; tick();
        chk("R9 frame after reload", rd_data, S_FRAME | S_BLOCK);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule